// File: doc/BRIEF.md
# SPI Flash Write Engine (Register-Launched Chunks)

This block is a single-lane SPI master that sends command and data bytes to a serial flash under software control. Software fills a 32-bit transmit word and picks how many of its bytes go out: one, two or four. The size is given by a 4-bit enable code. Writing a go command to the control word then starts the shift. The serial clock runs in mode 0 or mode 3. Completion is reported through an idle flag that software polls.

A flash command that is longer than four bytes is sent as a series of chunks. Software sets a hold-select flag on every chunk except the last one. While that flag is set, chip select stays asserted between chunks, and the following chunk starts shifting at once with no lead delay. Programmable lead, lag and release delays shape the timing of the select line. The data lane can be set to drive 0, drive 1, hold its last value or float while no bits are being shifted.

Top module: `spi_wr_engine`

## Requirements
- R1: The 4-bit size code in register 3 (bits 3:0) selects the length: 0x8 sends 8 bits, 0xC sends 16 bits and 0xF sends 32 bits. Starting with any other code does nothing: the idle flag stays 1 and chip select stays high.
- R2: The transmit word in register 2 is sent from its lowest byte upward. Bits 7:0 go first, then 15:8, then 23:16, then 31:24. Each byte is sent MSB first.
- R3: A transfer starts only when register 4 is written with bit 0 and bit 1 both set, and only while the block is idle. A write with just one of these bits set does not start a transfer.
- R4: If bit 8 is set in the starting write to register 4, chip select stays low after the shift and the block becomes idle with select still low. The next chunk then starts shifting in the cycle after its start write. If bit 8 is clear, the block runs the lag time, raises chip select, waits the release time and only then becomes idle.
- R5: Register 5 bit 0 is the idle flag. It reads 1 after reset and 0 from the cycle after a start is accepted. It reads 1 again once the transfer has fully ended.
- R6: Register 0 bit 0 sets the clock polarity, and the clock rests at that level whenever it is not shifting. Register 0 bit 1 sets the transmit phase. With phase 0, each bit is valid before the first clock edge of that bit. With phase 1, each bit changes on the first edge of that bit. In both cases the receiver samples on the edge in the middle of the bit. Register 0 bit 2 holds the receive phase setting. Each bit lasts 2*HALF_DIV system cycles.
- R7: Register 1 holds three delay fields: lead (bits 2:0), lag (bits 6:4) and release (bits 10:8). A field value n gives (n+1) SPI clock periods. All three fields reset to 3.
- R8: Register 0 bits 5:4 set the idle data lane: 0 drives 0, 1 drives 1, 2 holds the last bit sent, and 3 floats the lane (output enable low). The reset value is 3.
- R9: A start write that arrives while a transfer is in progress is ignored. The current transfer keeps its data, its length and its hold-select setting, and the idle flag stays 0.
- R10: After reset, chip select is high, the clock is low and the data lane is floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sd_o | output | 1 | Serial data out |
| spi_sd_oe | output | 1 | Data lane output enable |

## Verification
A start write sampled at edge E0 takes chip select low at E0 when select was released. The first half-bit then begins (lead+1)*2*HALF_DIV cycles later. When select is already held low, the first half-bit begins at E0 itself. The idle flag drops at E0 and rises again after the shift plus the lag and release times, or right after the shift when select is held.

The behavioural model in the bench updates on the same edge as the design. Every output is compared 2 ns after each rising edge, so all values are already settled. A bit catcher reads the data lane at each sampling edge of the clock. It rebuilds the bytes without using the model.

// File: rtl/spi_wr_engine.sv
module spi_wr_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_sd_o,
  output logic        spi_sd_oe
);
  localparam int PER = 2 * HALF_DIV;
  localparam int CW  = $clog2(8 * PER) + 1;
  localparam logic [2:0] A_CFG = 3'd0, A_DLY = 3'd1, A_WDAT = 3'd2,
                         A_SIZE = 3'd3, A_CTRL = 3'd4, A_STAT = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG, S_GAP} st_t;
  st_t st;

  logic        cpol, cpha_tx, cpha_rx;
  logic [1:0]  idle_md;
  logic [2:0]  d_lead, d_lag, d_gap;
  logic [31:0] wdat, sr;
  logic [3:0]  size_cd;
  logic [CW-1:0] cnt;
  logic [4:0]  bits_left, nbits_m1;
  logic        ph, keep_q, last_bit, cs_n_q, size_ok;

  always_comb begin
    size_ok  = 1'b1;
    nbits_m1 = 5'd7;
    case (size_cd)
      4'h8:    nbits_m1 = 5'd7;
      4'hC:    nbits_m1 = 5'd15;
      4'hF:    nbits_m1 = 5'd31;
      default: size_ok  = 1'b0;
    endcase
  end

  wire ctl_wr = bus_wr && (bus_addr == A_CTRL);
  wire start  = ctl_wr && (bus_wdata[1:0] == 2'b11) && size_ok && (st == S_IDLE);

  function automatic logic [CW-1:0] dly(input logic [2:0] f);
    return CW'((32'(f) + 1) * PER - 1);
  endfunction

  localparam logic [CW-1:0] HALF_LD = CW'(HALF_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol <= 1'b0; cpha_tx <= 1'b0; cpha_rx <= 1'b0; idle_md <= 2'b11;
      d_lead <= 3'd3; d_lag <= 3'd3; d_gap <= 3'd3;
      wdat <= '0; size_cd <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CFG:  begin
          cpol <= bus_wdata[0]; cpha_tx <= bus_wdata[1];
          cpha_rx <= bus_wdata[2]; idle_md <= bus_wdata[5:4];
        end
        A_DLY:  begin
          d_lead <= bus_wdata[2:0]; d_lag <= bus_wdata[6:4]; d_gap <= bus_wdata[10:8];
        end
        A_WDAT: wdat <= bus_wdata;
        A_SIZE: size_cd <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bits_left <= '0; ph <= 1'b0; sr <= '0;
      keep_q <= 1'b0; last_bit <= 1'b0; cs_n_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sr        <= {wdat[7:0], wdat[15:8], wdat[23:16], wdat[31:24]};
          keep_q    <= bus_wdata[8];
          bits_left <= nbits_m1;
          ph        <= 1'b0;
          if (cs_n_q) begin
            st <= S_LEAD; cs_n_q <= 1'b0; cnt <= dly(d_lead);
          end else begin
            st <= S_SHIFT; cnt <= HALF_LD;
          end
        end
        S_LEAD: if (cnt == '0) begin
          st <= S_SHIFT; cnt <= HALF_LD;
        end else cnt <= cnt - 1'b1;
        S_SHIFT: begin
          last_bit <= sr[31];
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!ph) begin
            ph <= 1'b1; cnt <= HALF_LD;
          end else if (bits_left != '0) begin
            ph <= 1'b0; bits_left <= bits_left - 1'b1; sr <= sr << 1; cnt <= HALF_LD;
          end else if (keep_q) st <= S_IDLE;
          else begin
            st <= S_LAG; cnt <= dly(d_lag);
          end
        end
        S_LAG: if (cnt == '0) begin
          st <= S_GAP; cs_n_q <= 1'b1; cnt <= dly(d_gap);
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign spi_sck   = (st == S_SHIFT) ? (cpol ^ (cpha_tx ? ~ph : ph)) : cpol;
  assign spi_cs_n  = cs_n_q;
  assign spi_sd_oe = (st == S_SHIFT) || (idle_md != 2'b11);
  assign spi_sd_o  = (st == S_SHIFT) ? sr[31] :
                     (idle_md == 2'b01) ? 1'b1 :
                     (idle_md == 2'b10) ? last_bit : 1'b0;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {26'd0, idle_md, 1'b0, cpha_rx, cpha_tx, cpol};
      A_DLY:   bus_rdata = {21'd0, d_gap, 1'b0, d_lag, 1'b0, d_lead};
      A_WDAT:  bus_rdata = wdat;
      A_SIZE:  bus_rdata = {28'd0, size_cd};
      A_CTRL:  bus_rdata = {23'd0, keep_q, 8'd0};
      A_STAT:  bus_rdata = {31'd0, st == S_IDLE};
      default: bus_rdata = '0;
    endcase
  end

  AST_KEEP_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && keep_q) |=> !spi_cs_n); // R4
  AST_SCK_RESTS_AT_CPOL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (spi_sck == cpol)); // R6
  AST_SHIFT_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> !spi_cs_n); // R7
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && st == S_SHIFT) |=> $stable(keep_q)); // R9
  AST_BAD_SIZE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ctl_wr && !size_ok) |=> (st == S_IDLE)); // R1
endmodule

// File: tb/spi_wr_engine_tb.sv
module spi_wr_engine_tb;
  localparam int HALF = 2;
  localparam int P = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd5;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sck, spi_cs_n, spi_sd_o, spi_sd_oe;

  spi_wr_engine #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_sd_o(spi_sd_o), .spi_sd_oe(spi_sd_oe));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int  m_ph, m_t, m_n;          // 0 idle,1 lead,2 shift,3 lag,4 gap
  bit  m_csn, m_hold, m_keep;
  bit  m_bits[32];
  int  s_lead, s_lag, s_gap, s_idle;
  bit  s_cpol, s_cpha;
  logic [31:0] s_wdat;
  logic [3:0]  s_code;

  function automatic int code_len(logic [3:0] c);
    return (c == 4'h8) ? 8 : (c == 4'hC) ? 16 : (c == 4'hF) ? 32 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_n = 8; m_csn = 1; m_hold = 0; m_keep = 0;
      s_lead = 3; s_lag = 3; s_gap = 3; s_idle = 3; s_cpol = 0; s_cpha = 0;
      s_wdat = '0; s_code = '0;
    end else begin
      case (m_ph)
        0: if (bus_wr && bus_addr == 3'd4 && bus_wdata[1:0] == 2'b11 && code_len(s_code) != 0) begin
             m_n = code_len(s_code);
             for (int k = 0; k < 32; k++) m_bits[k] = s_wdat[(k / 8) * 8 + 7 - (k % 8)];
             m_keep = bus_wdata[8];
             m_t = 0;
             if (m_csn) begin m_ph = 1; m_csn = 0; end else m_ph = 2;
           end
        1: begin m_t++; if (m_t == (s_lead + 1) * P) begin m_ph = 2; m_t = 0; end end
        2: begin
             m_t++;
             if (m_t == m_n * P) begin
               m_hold = m_bits[m_n - 1]; m_t = 0; m_ph = m_keep ? 0 : 3;
             end
           end
        3: begin m_t++; if (m_t == (s_lag + 1) * P) begin m_ph = 4; m_t = 0; m_csn = 1; end end
        4: begin m_t++; if (m_t == (s_gap + 1) * P) begin m_ph = 0; m_t = 0; end end
        default: m_ph = 0;
      endcase
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin s_cpol = bus_wdata[0]; s_cpha = bus_wdata[1]; s_idle = int'(bus_wdata[5:4]); end
          3'd1: begin s_lead = int'(bus_wdata[2:0]); s_lag = int'(bus_wdata[6:4]); s_gap = int'(bus_wdata[10:8]); end
          3'd2: s_wdat = bus_wdata;
          3'd3: s_code = bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison and bit catcher ----------------
  bit cap[$];
  bit prev_sck = 0, prev_sd = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit hb, e_sck, e_sd, e_oe;
      hb    = (m_t % P) >= HALF;
      e_sck = (m_ph == 2) ? (s_cpol ^ (s_cpha ? !hb : hb)) : s_cpol;
      e_oe  = (m_ph == 2) || (s_idle != 3);
      e_sd  = (m_ph == 2) ? m_bits[m_t / P] :
              (s_idle == 1) ? 1'b1 : (s_idle == 2) ? m_hold : 1'b0;
      chk("R7 cs_n", spi_cs_n, m_csn);
      chk("R6 sck", spi_sck, e_sck);
      chk("R8 sd_oe", spi_sd_oe, e_oe);
      if (e_oe) chk("R2 sd", spi_sd_o, e_sd);
      if (!bus_wr && bus_addr == 3'd5) chk("R5 idle flag", bus_rdata[0], m_ph == 0);
      if (!spi_cs_n && spi_sck != prev_sck && spi_sck == (s_cpha ? s_cpol : !s_cpol))
        cap.push_back(prev_sd);
      prev_sck = spi_sck;
      prev_sd  = spi_sd_o;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 3'd5; bus_wdata = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (bus_rdata[0] !== 1'b1);
  endtask

  function automatic int cap_byte(int i);
    int v = 0;
    for (int k = 0; k < 8; k++) v = (v << 1) | int'(cap[i * 8 + k]);
    return v;
  endfunction

  task automatic xfer(logic [3:0] code, logic [31:0] data, logic [31:0] ctrl);
    wr(3'd3, {28'd0, code});
    wr(3'd2, data);
    wr(3'd4, ctrl);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cs_n", spi_cs_n, 1);
    chk("R10 sck", spi_sck, 0);
    chk("R10 sd_oe", spi_sd_oe, 0);
    chk("R5 idle after reset", bus_rdata[0], 1);
    bus_addr = 3'd1; #1; chk("R7 delay reset", bus_rdata, 32'h333);
    bus_addr = 3'd0; #1; chk("R8 idle lane reset", bus_rdata, 32'h30);
    bus_addr = 3'd5;

    // R1 / R2 sizes and order, mode 0
    cap.delete(); xfer(4'h8, 32'h0000_00A5, 32'h3);
    chk("R1 8-bit count", cap.size(), 8);
    chk("R2 8-bit byte", cap_byte(0), 8'hA5);

    cap.delete(); xfer(4'hC, 32'h0000_3C81, 32'h3);
    chk("R1 16-bit count", cap.size(), 16);
    chk("R2 16-bit b0", cap_byte(0), 8'h81);
    chk("R2 16-bit b1", cap_byte(1), 8'h3C);

    cap.delete(); xfer(4'hF, 32'h1234_5678, 32'h3);
    chk("R1 32-bit count", cap.size(), 32);
    chk("R2 32-bit b0", cap_byte(0), 8'h78);
    chk("R2 32-bit b3", cap_byte(3), 8'h12);

    // R6 mode 3
    wr(3'd0, 32'h33);
    @(negedge clk); chk("R6 sck rests high", spi_sck, 1);
    cap.delete(); xfer(4'hF, 32'hF0E1_D2C3, 32'h3);
    chk("R6 mode3 b0", cap_byte(0), 8'hC3);
    chk("R6 mode3 b2", cap_byte(2), 8'hE1);

    // R4 keep select across chunks, idle lane drives 1
    wr(3'd0, 32'h10);
    cap.delete(); xfer(4'h8, 32'h9E, 32'h103);
    chk("R4 cs held", spi_cs_n, 0);
    chk("R4 idle while held", bus_rdata[0], 1);
    chk("R8 drive one", spi_sd_o, 1);
    xfer(4'hC, 32'hBEEF, 32'h3);
    chk("R4 joined length", cap.size(), 24);
    chk("R4 joined b1", cap_byte(1), 8'hEF);
    chk("R4 joined b2", cap_byte(2), 8'hBE);
    chk("R4 cs released", spi_cs_n, 1);

    // R8 hold last bit
    wr(3'd0, 32'h20);
    cap.delete(); xfer(4'h8, 32'h01, 32'h3);
    chk("R8 hold oe", spi_sd_oe, 1);
    chk("R8 hold value", spi_sd_o, 1);

    // R1 invalid code ignored
    wr(3'd3, 32'h4);
    cap.delete(); wr(3'd4, 32'h3);
    @(negedge clk);
    chk("R1 bad code idle", bus_rdata[0], 1);
    chk("R1 bad code cs", spi_cs_n, 1);

    // R3 partial go bits
    wr(3'd3, 32'h8);
    wr(3'd4, 32'h1);
    @(negedge clk); chk("R3 only bit0", bus_rdata[0], 1);
    wr(3'd4, 32'h2);
    @(negedge clk); chk("R3 only bit1", bus_rdata[0], 1);
    chk("R3 no bits", cap.size(), 0);

    // R9 start while busy
    cap.delete();
    wr(3'd2, 32'h5A);
    wr(3'd4, 32'h3);
    wr(3'd2, 32'hFF);
    wr(3'd4, 32'h103);
    chk("R9 still busy", bus_rdata[0], 0);
    wait_idle();
    chk("R9 original data", cap_byte(0), 8'h5A);
    chk("R9 length kept", cap.size(), 8);
    chk("R9 keep ignored", spi_cs_n, 1);

    // R7 lead delay 0, lag 5, release 1
    wr(3'd1, 32'h150);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h3C);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h3;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 3'd5; bus_wdata = '0;
    begin
      int n = 1;
      forever begin
        @(posedge clk); #2;
        if (spi_sck == 1'b0) n++; else break;
      end
      chk("R7 lead length", n, (0 + 1) * P + HALF);
    end
    wait_idle();
    repeat (4) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule